// File: doc/BRIEF.md
# Serial Transmit Word Packer

This block sits between a simple register bus and a single-bit serial flash link. Software writes 32-bit words into a transmit queue. It can use any of four write ports, and the port chosen fixes how many bytes of that word, one to four, go on the wire. A shift engine takes queued entries one at a time. It sends the valid bytes lowest lane first, with each byte MSB first, and moves one bit per `sclk_tick` pulse. The serial clock itself comes from outside the block. In the same bit slots it samples the return line. When an entry finishes, it places one word in a receive queue, which software drains through a read-only port.

A receive word for a short entry is packed toward the top of the word. The first received byte lands in the lowest valid lane, and the lanes below it read as zero. A configuration write can hold the engine idle until software gives an explicit start. The engine then drains everything that is queued. Both queues drop writes when they are full and raise a sticky flag when they do.

Top module: `qpk_tx_packer`

## Requirements
- R1: A write to address 0x80, 0x84, 0x88 or 0x1C queues an entry of 1, 2, 3 or 4 bytes respectively; the entry keeps `busy` high for exactly 8 bits per byte worth of `sclk_tick` pulses.
- R2: `spi_mosi` presents byte lane 0 (bits 7:0) first, then lanes 1, 2, 3, each byte MSB first; it advances one bit per tick, changes only on the cycle after a tick, and is 0 while idle.
- R3: One `spi_miso` sample is taken per tick. In the receive word of an N-byte entry, the first received byte sits in lane 4-N and later bytes sit in the higher lanes, each byte assembled MSB first. Lanes below 4-N read zero.
- R4: Every entry taken from the transmit queue produces exactly one receive queue push when its last bit is sampled.
- R5: A read at address 0x20 returns the oldest receive word and removes it. A read at that address with the queue empty returns 0. Reads at other addresses, and writes to 0x20 or to any address not listed in R1 or R9, change nothing.
- R6: Each queue holds 63 entries; `tx_full` rises after 63 queued writes and 63 receive words can be read back.
- R7: A transmit write while the transmit queue is full is discarded and sets `tx_ovf`, which stays set until reset.
- R8: A receive push while the receive queue is full is discarded and sets `rx_ovf`, which stays set until reset.
- R9: A write to address 0x00 loads manual mode from data bit 15. In manual mode no entry starts until a write to 0x00 with bit 16 set; the engine then drains the queue and re-arms the hold once it is idle with an empty queue.
- R10: With manual mode off, an entry starts on the second clock after the write that queued it, provided the engine is idle.
- R11: After reset both queues are empty, both flags are clear, `busy` and `spi_mosi` are 0, manual mode is off and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Head of the receive queue, 0 when empty |
| sclk_tick | input | 1 | One pulse per serial bit slot |
| spi_miso | input | 1 | Serial return data |
| spi_mosi | output | 1 | Serial transmit data |
| busy | output | 1 | An entry is being shifted |
| tx_full | output | 1 | Transmit queue holds 63 entries |
| tx_empty | output | 1 | Transmit queue is empty |
| rx_empty | output | 1 | Receive queue is empty |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_ovf | output | 1 | Sticky receive overflow |

## Verification
The hardest case to reach is a receive overflow. It needs 63 finished entries waiting unread in the receive queue and then one more entry to complete. The bench holds the engine in manual mode while it overfills the transmit queue, which also covers the transmit overflow. It then releases the queue with a start write and runs the clock tick on every cycle so that the drain is short. A single extra entry after that pushes into a full receive queue. A behavioural queue model runs through the whole sequence, including random tick and return-line patterns, and is compared with every output on every cycle.

// File: rtl/qpk_pkg.sv
package qpk_pkg;
    localparam int WORD_W  = 32;
    localparam int BYTES   = WORD_W / 8;
    localparam int NB_W    = $clog2(BYTES);
    localparam int BIT_W   = $clog2(WORD_W);

    localparam logic [7:0] ADR_CFG = 8'h00;
    localparam logic [7:0] ADR_TX4 = 8'h1C;
    localparam logic [7:0] ADR_RX  = 8'h20;
    localparam logic [7:0] ADR_TX1 = 8'h80;
    localparam logic [7:0] ADR_TX2 = 8'h84;
    localparam logic [7:0] ADR_TX3 = 8'h88;

    typedef struct packed {
        logic [NB_W-1:0]   nb_m1;
        logic [WORD_W-1:0] data;
    } tx_ent_t;
endpackage

// File: rtl/qpk_fifo.sv
module qpk_fifo #(
    parameter int W     = 34,
    parameter int DEPTH = 63
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } fst_t;

    fst_t st_q, st_d;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign head  = mem_q[st_q.rd];

    always_comb begin
        do_push = push & ~full;
        do_pop  = pop & ~empty;
        st_d    = st_q;
        if (do_push)
            st_d.wr = (st_q.wr == PW'(DEPTH - 1)) ? '0 : st_q.wr + PW'(1);
        if (do_pop)
            st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + PW'(1);
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= push_data;
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/qpk_shift_eng.sv
module qpk_shift_eng
    import qpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_tick,
    input  logic              miso,
    input  logic              start_ok,
    input  logic              ent_valid,
    input  tx_ent_t           ent,
    output logic              ent_pop,
    output logic              mosi,
    output logic              busy,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word
);
    typedef struct packed {
        logic              active;
        logic [WORD_W-1:0] word;
        logic [NB_W-1:0]   nb_m1;
        logic [BIT_W-1:0]  bitc;
        logic [7:0]        rbyte;
        logic [WORD_W-1:0] rword;
    } est_t;

    est_t st_q, st_d;
    logic [7:0]        rbyte_n;
    logic [WORD_W-1:0] rword_n;
    logic [BIT_W-1:0]  last_bit;

    assign busy = st_q.active;
    assign mosi = st_q.active & st_q.word[{st_q.bitc[BIT_W-1:3], ~st_q.bitc[2:0]}];

    always_comb begin
        st_d     = st_q;
        ent_pop  = 1'b0;
        rx_push  = 1'b0;
        rbyte_n  = {st_q.rbyte[6:0], miso};
        rword_n  = st_q.rword;
        last_bit = {st_q.nb_m1, 3'b111};
        if (!st_q.active) begin
            if (ent_valid && start_ok) begin
                ent_pop     = 1'b1;
                st_d.active = 1'b1;
                st_d.word   = ent.data;
                st_d.nb_m1  = ent.nb_m1;
                st_d.bitc   = '0;
                st_d.rbyte  = '0;
                st_d.rword  = '0;
            end
        end else if (sclk_tick) begin
            st_d.rbyte = rbyte_n;
            st_d.bitc  = st_q.bitc + BIT_W'(1);
            if (st_q.bitc[2:0] == 3'd7) begin
                rword_n    = {rbyte_n, st_q.rword[WORD_W-1:8]};
                st_d.rword = rword_n;
            end
            if (st_q.bitc == last_bit) begin
                rx_push     = 1'b1;
                st_d.active = 1'b0;
            end
        end
        rx_word = rword_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sclk_tick) |=> (busy && $stable(mosi)));

    // R4
    push_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !busy);

    // R1
    pop_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_pop |=> busy);
endmodule

// File: rtl/qpk_tx_packer.sv
module qpk_tx_packer
    import qpk_pkg::*;
#(
    parameter int TX_DEPTH = 63,
    parameter int RX_DEPTH = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              sclk_tick,
    input  logic              spi_miso,
    output logic              spi_mosi,
    output logic              busy,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              rx_empty,
    output logic              tx_ovf,
    output logic              rx_ovf
);
    localparam int TXE_W = $bits(tx_ent_t);

    typedef struct packed {
        logic man;
        logic run;
        logic tx_ovf;
        logic rx_ovf;
    } cst_t;

    cst_t st_q, st_d;

    logic              tx_wr, cfg_wr, rx_rd, start_ok;
    logic [NB_W-1:0]   wr_nb_m1;
    tx_ent_t           tx_in, tx_head;
    logic [TXE_W-1:0]  tx_head_raw;
    logic              tx_pop, rx_push, rx_full;
    logic [WORD_W-1:0] rx_word, rx_head;

    always_comb begin
        tx_wr    = 1'b0;
        wr_nb_m1 = '0;
        unique case (bus_addr)
            ADR_TX1: begin tx_wr = bus_wr; wr_nb_m1 = NB_W'(0); end
            ADR_TX2: begin tx_wr = bus_wr; wr_nb_m1 = NB_W'(1); end
            ADR_TX3: begin tx_wr = bus_wr; wr_nb_m1 = NB_W'(2); end
            ADR_TX4: begin tx_wr = bus_wr; wr_nb_m1 = NB_W'(3); end
            default: ;
        endcase
        cfg_wr      = bus_wr && (bus_addr == ADR_CFG);
        rx_rd       = bus_rd && (bus_addr == ADR_RX);
        tx_in.nb_m1 = wr_nb_m1;
        tx_in.data  = bus_wdata;
    end

    always_comb begin
        st_d = st_q;
        if (cfg_wr) st_d.man = bus_wdata[15];
        if (cfg_wr && bus_wdata[16])
            st_d.run = 1'b1;
        else if (st_q.run && !busy && tx_empty)
            st_d.run = 1'b0;
        if (tx_wr && tx_full)   st_d.tx_ovf = 1'b1;
        if (rx_push && rx_full) st_d.rx_ovf = 1'b1;
        start_ok = !st_q.man || st_q.run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    qpk_fifo #(.W(TXE_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_wr), .push_data(tx_in),
        .pop(tx_pop), .head(tx_head_raw),
        .full(tx_full), .empty(tx_empty)
    );

    assign tx_head = tx_ent_t'(tx_head_raw);

    qpk_shift_eng u_eng (
        .clk(clk), .rst_n(rst_n),
        .sclk_tick(sclk_tick), .miso(spi_miso),
        .start_ok(start_ok), .ent_valid(!tx_empty), .ent(tx_head),
        .ent_pop(tx_pop), .mosi(spi_mosi), .busy(busy),
        .rx_push(rx_push), .rx_word(rx_word)
    );

    qpk_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_word),
        .pop(rx_rd), .head(rx_head),
        .full(rx_full), .empty(rx_empty)
    );

    assign bus_rdata = rx_empty ? '0 : rx_head;
    assign tx_ovf    = st_q.tx_ovf;
    assign rx_ovf    = st_q.rx_ovf;

    // R7
    tx_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf |=> tx_ovf);

    // R8
    rx_ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> rx_ovf);

    // R9
    man_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.man && !st_q.run && !busy) |=> !busy);
endmodule

// File: tb/test_qpk_tx_packer.sv
module test_qpk_tx_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk_tick = 1'b0, spi_miso = 1'b0;
    logic        spi_mosi, busy, tx_full, tx_empty, rx_empty, tx_ovf, rx_ovf;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int tick_mode = 0, miso_mode = 0;
    bit cmp_en = 0;

    qpk_tx_packer i_qpk_tx_packer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk_tick(sclk_tick), .spi_miso(spi_miso), .spi_mosi(spi_mosi),
        .busy(busy), .tx_full(tx_full), .tx_empty(tx_empty), .rx_empty(rx_empty),
        .tx_ovf(tx_ovf), .rx_ovf(rx_ovf)
    );

    always #2 clk = ~clk;

    // reference model state
    logic [31:0] m_txd[$];
    int          m_txn[$];
    logic [31:0] m_rx[$];
    bit          m_active, m_man, m_run, m_txovf, m_rxovf;
    logic [31:0] m_word;
    int          m_n, m_bit;
    logic [7:0]  m_acc;
    logic [7:0]  m_bytes[4];

    function automatic int tx_bytes_of(logic [7:0] a);
        case (a)
            8'h80: return 1;
            8'h84: return 2;
            8'h88: return 3;
            8'h1C: return 4;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_txd.delete(); m_txn.delete(); m_rx.delete();
            m_active = 0; m_man = 0; m_run = 0; m_txovf = 0; m_rxovf = 0;
            m_word = '0; m_n = 0; m_bit = 0; m_acc = '0;
        end else begin
            int txsz, rxsz;
            bit was_active, push_rx;
            logic [31:0] pw;
            txsz = m_txd.size();
            rxsz = m_rx.size();
            was_active = m_active;
            push_rx = 0;
            pw = '0;
            if (!m_active && txsz > 0 && (!m_man || m_run)) begin
                m_word = m_txd.pop_front();
                m_n = m_txn.pop_front();
                m_active = 1; m_bit = 0; m_acc = '0;
            end else if (m_active && sclk_tick) begin
                m_acc = {m_acc[6:0], spi_miso};
                if (m_bit % 8 == 7) m_bytes[m_bit / 8] = m_acc;
                m_bit++;
                if (m_bit == 8 * m_n) begin
                    for (int k = 0; k < m_n; k++) pw[8 * (4 - m_n + k) +: 8] = m_bytes[k];
                    push_rx = 1;
                    m_active = 0;
                end
            end
            if (bus_wr && tx_bytes_of(bus_addr) != 0) begin
                if (txsz == 63) m_txovf = 1;
                else begin m_txd.push_back(bus_wdata); m_txn.push_back(tx_bytes_of(bus_addr)); end
            end
            if (bus_rd && bus_addr == 8'h20 && rxsz > 0) void'(m_rx.pop_front());
            if (push_rx) begin
                if (rxsz == 63) m_rxovf = 1;
                else m_rx.push_back(pw);
            end
            if (bus_wr && bus_addr == 8'h00) m_man = bus_wdata[15];
            if (bus_wr && bus_addr == 8'h00 && bus_wdata[16]) m_run = 1;
            else if (m_run && !was_active && txsz == 0) m_run = 0;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            chk("R2", "mosi", {31'd0, spi_mosi},
                m_active ? {31'd0, m_word[8 * (m_bit / 8) + 7 - (m_bit % 8)]} : 32'd0);
            chk("R1", "busy", {31'd0, busy}, {31'd0, m_active});
            chk("R6", "tx_full", {31'd0, tx_full}, {31'd0, m_txd.size() == 63});
            chk("R6", "tx_empty", {31'd0, tx_empty}, {31'd0, m_txd.size() == 0});
            chk("R4", "rx_empty", {31'd0, rx_empty}, {31'd0, m_rx.size() == 0});
            chk("R3", "rdata", bus_rdata, (m_rx.size() == 0) ? 32'd0 : m_rx[0]);
            chk("R7", "tx_ovf", {31'd0, tx_ovf}, {31'd0, m_txovf});
            chk("R8", "rx_ovf", {31'd0, rx_ovf}, {31'd0, m_rxovf});
        end
    end

    // serial stimulus
    always @(negedge clk) begin
        sclk_tick = (tick_mode == 1) ? 1'b1 : ($urandom_range(0, 2) == 0);
        spi_miso  = (miso_mode == 1) ? 1'b1 : 1'($urandom_range(0, 1));
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected under 150000", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        v = bus_rdata;
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic wait_idle();
        while (m_active || m_txd.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    // count busy cycles and capture mosi for one entry (tick every cycle)
    task automatic run_one(logic [7:0] a, logic [31:0] d, output int nb, output logic [31:0] bits);
        nb = 0; bits = '0;
        wr(a, d);
        for (int g = 0; g < 10 && !busy; g++) @(negedge clk);
        while (busy) begin
            bits = {bits[30:0], spi_mosi};
            nb++;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] v;
        int nb;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "tx_empty", {31'd0, tx_empty}, 32'd1);
        chk("R11", "rx_empty", {31'd0, rx_empty}, 32'd1);
        chk("R11", "busy", {31'd0, busy}, 32'd0);
        chk("R11", "mosi", {31'd0, spi_mosi}, 32'd0);
        chk("R11", "flags", {30'd0, tx_ovf, rx_ovf}, 32'd0);
        chk("R11", "rdata", bus_rdata, 32'd0);
        cmp_en = 1;

        // R10 auto mode, random ticks and return data
        wr(8'h80, 32'h1234_56A5);
        chk("R10", "queued", {31'd0, tx_empty}, 32'd0);
        @(negedge clk);
        chk("R10", "started", {31'd0, busy}, 32'd1);
        wr(8'h84, 32'hDEAD_C35A);
        wr(8'h88, 32'h00F0_0F81);
        wr(8'h1C, 32'h8899_AABB);
        wait_idle();
        for (int i = 0; i < 4; i++) rd(8'h20, v);
        chk("R4", "four entries read back", {31'd0, rx_empty}, 32'd1);

        // R1 / R2 with one tick per cycle
        tick_mode = 1;
        run_one(8'h80, 32'hFFFF_FFA5, nb, v);
        chk("R1", "1-byte bits", nb, 8);
        chk("R2", "1-byte order", v, 32'h0000_00A5);
        run_one(8'h84, 32'h0000_C35A, nb, v);
        chk("R1", "2-byte bits", nb, 16);
        chk("R2", "2-byte order", v, 32'h0000_5AC3);
        run_one(8'h88, 32'h0011_2233, nb, v);
        chk("R1", "3-byte bits", nb, 24);
        run_one(8'h1C, 32'h0102_0304, nb, v);
        chk("R1", "4-byte bits", nb, 32);
        chk("R2", "4-byte order", v, 32'h0403_0201);
        wait_idle();
        for (int i = 0; i < 4; i++) rd(8'h20, v);

        // R3 alignment with constant return data
        miso_mode = 1;
        wr(8'h80, 32'h0);
        wait_idle();
        rd(8'h20, v);
        chk("R3", "1-byte rx word", v, 32'hFF00_0000);
        wr(8'h88, 32'h0);
        wait_idle();
        rd(8'h20, v);
        chk("R3", "3-byte rx word", v, 32'hFFFF_FF00);
        miso_mode = 0;

        // R5 ignored accesses
        wr(8'h20, 32'h1234_5678);
        wr(8'h44, 32'h1234_5678);
        @(negedge clk);
        chk("R5", "ignored writes tx_empty", {31'd0, tx_empty}, 32'd1);
        chk("R5", "ignored writes busy", {31'd0, busy}, 32'd0);
        rd(8'h20, v);
        chk("R5", "empty read", v, 32'd0);
        wr(8'h84, 32'h0000_1111);
        wait_idle();
        v = bus_rdata;
        rd(8'h24, nb == 0 ? v : v);
        chk("R5", "other-address read keeps rx", {31'd0, rx_empty}, 32'd0);
        rd(8'h20, v);

        // R9 manual start
        tick_mode = 0;
        wr(8'h00, 32'h0000_8000);
        wr(8'h80, 32'h0000_0011);
        wr(8'h1C, 32'h2233_4455);
        repeat (20) @(negedge clk);
        chk("R9", "held busy", {31'd0, busy}, 32'd0);
        chk("R9", "held queue", {31'd0, tx_empty}, 32'd0);
        wr(8'h00, 32'h0001_8000);
        wait_idle();
        chk("R9", "drained", {31'd0, tx_empty}, 32'd1);
        rd(8'h20, v);
        rd(8'h20, v);
        wr(8'h80, 32'h0000_0077);
        repeat (10) @(negedge clk);
        chk("R9", "hold re-armed", {31'd0, busy}, 32'd0);
        wr(8'h00, 32'h0001_8000);
        wait_idle();
        rd(8'h20, v);

        // R6 / R7 transmit overflow while held
        for (int i = 0; i < 64; i++) wr(8'h1C, 32'hA000_0000 + i);
        chk("R6", "tx_full at 63", {31'd0, tx_full}, 32'd1);
        chk("R7", "tx_ovf", {31'd0, tx_ovf}, 32'd1);
        tick_mode = 1;
        wr(8'h00, 32'h0001_8000);
        wait_idle();
        chk("R8", "no rx overflow at 63", {31'd0, rx_ovf}, 32'd0);
        wr(8'h80, 32'h0000_00C3);
        wr(8'h00, 32'h0001_8000);
        wait_idle();
        chk("R8", "rx_ovf", {31'd0, rx_ovf}, 32'd1);
        for (int i = 0; i < 62; i++) rd(8'h20, v);
        chk("R6", "rx holds 63", {31'd0, rx_empty}, 32'd0);
        rd(8'h20, v);
        chk("R6", "rx empty after 63", {31'd0, rx_empty}, 32'd1);
        chk("R7", "tx_ovf sticky", {31'd0, tx_ovf}, 32'd1);

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule